// File: doc/BRIEF.md
# Sector page-load program controller

This block models the write side of a byte-wide, sectored nonvolatile memory. It runs on a free-running clock. Its active-low chip-select, output-enable and write-enable strobes, the address bus and the data bus all arrive asynchronously, so the block samples them through a synchronizer. Address and data pass through the same register depth as the strobes, so every captured value lines up with the strobe edge that captured it.

A byte load places one byte into a 128-entry sector buffer. Bytes may arrive in any order. The load phase has no closing command. It ends when no new write pulse begins within a window after the previous one finished.

The block then runs a timed internal cycle in two steps. First it erases the whole target sector to the undefined value. Then it writes back every buffered byte. While this cycle runs, any read returns a polling word whose top bit is the inverse of the last loaded byte's top bit. Once the cycle ends, reads return the stored bytes again. The storage array is an internal register file of 2^ADDR_W bytes.

Top module: `sector_prog_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle. At the following edge dq_oe is 0 and dq_out is 8'h00.
- R2: A write pulse is accepted as a byte load only while ce_n is low, we_n is low and oe_n is high. Address bits ADDR_W-1 down to 7 name the sector and bits 6 down to 0 name the byte in it. A full sector loaded in any order reads back byte for byte after programming.
- R3: The address is taken when the later of the ce_n and we_n falling edges makes the pulse begin. The data is taken when the earlier of their rising edges ends it.
- R4: The sector of a cycle is set by the first accepted load of that cycle. Later loads in the same cycle use only their byte bits.
- R5: A load whose pulse begins within LOAD_WIN clock cycles after the previous pulse ended joins the same cycle. If no pulse begins in that window, programming starts, and any later load opens a new cycle with an empty buffer.
- R6: Programming first erases every byte of the target sector. A byte that was not loaded in the cycle then reads 8'hFF (UNDEF_X = 0).
- R7: While programming runs, a read (ce_n low, oe_n low, we_n high) drives dq_oe high. The read returns dq_out[7] equal to the inverse of bit 7 of the last loaded byte, with dq_out[6:0] equal to 0.
- R8: Programming lasts PROG_CYC clock cycles. After that, reads return the stored bytes on all bits.
- R9: Write pulses that begin while programming runs are ignored. They change no stored byte and start no new cycle.
- R10: A write-enable pulse given while oe_n is held low is not a load. It changes no byte and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address: sector in the upper bits, byte in bits 6:0 |
| din | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data or polling word, 0 when not reading |
| dq_oe | output | 1 | High while a read is being served |

## Verification
The bench builds the block with ADDR_W = 9, which gives four sectors. It uses LOAD_WIN = 40 and PROG_CYC = 300. With these values, a whole sector can be swept byte by byte after every cycle, and the window can be let lapse between two loads at little cost. A polling read can also be placed both early in the cycle and well into its run. The short program cycle is what makes it practical to inject a write pulse during programming and to compare erased and loaded bytes across several sectors.

// File: rtl/spc_pkg.sv
// Shared definitions for the sector program controller.
// Assumes a fixed sector of 2^BYTE_BITS bytes.
package spc_pkg;
    localparam int BYTE_BITS = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } spc_state_t;
endpackage

// File: rtl/spc_strobe_sync.sv
// Brings the asynchronous strobes, address and data into the clock domain.
// Address and data pass through the same two stages as the strobes, so the
// values that pulse edges capture stay aligned. Data has one more stage, so
// the value seen on the last active cycle is still present at the end edge.
// Assumes bus values are held steady for a few clocks around each strobe edge.
module spc_strobe_sync #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_start,
    output logic              wr_end,
    output logic              rd_act,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] data_end
);
    logic [2:0]        ctl1, ctl2;   // {ce_n, oe_n, we_n}
    logic [ADDR_W-1:0] addr1, addr2;
    logic [DATA_W-1:0] din1, din2, din3;
    logic              wr_prev;
    logic              wr_now;

    // Two-stage synchronizer with aligned bus stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl1    <= 3'b111;
            ctl2    <= 3'b111;
            addr1   <= '0;
            addr2   <= '0;
            din1    <= '0;
            din2    <= '0;
            din3    <= '0;
            wr_prev <= 1'b0;
        end else begin
            ctl1    <= {ce_n, oe_n, we_n};
            ctl2    <= ctl1;
            addr1   <= addr;
            addr2   <= addr1;
            din1    <= din;
            din2    <= din1;
            din3    <= din2;
            wr_prev <= wr_now;
        end
    end

    // Decode the synchronized strobes into write and read conditions.
    always_comb begin
        wr_now   = !ctl2[2] && !ctl2[0] && ctl2[1];
        rd_act   = !ctl2[2] && !ctl2[1] && ctl2[0];
        wr_start = wr_now && !wr_prev;
        wr_end   = !wr_now && wr_prev;
        addr_s   = addr2;
        data_end = din3;
    end
endmodule

// File: rtl/spc_seq.sv
// Sequencer: idle, load window, and the timed erase-then-fill program cycle.
// Erase runs over the first 2^BYTE_BITS program counts and fill over the next
// 2^BYTE_BITS, so PROG_CYC must be at least twice the sector size.
module spc_seq
    import spc_pkg::*;
#(
    parameter int LOAD_WIN = 40,
    parameter int PROG_CYC = 300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_start,
    input  logic                 wr_end,
    output spc_state_t           state,
    output logic                 acc_start,
    output logic                 acc_end,
    output logic                 new_cycle,
    output logic                 wipe_we,
    output logic                 fill_we,
    output logic [BYTE_BITS-1:0] idx
);
    localparam int SECT  = 1 << BYTE_BITS;
    localparam int WIN_W = $clog2(LOAD_WIN + 1);
    localparam int PRG_W = $clog2(PROG_CYC + 1);

    logic             armed;
    logic [WIN_W-1:0] win_cnt;
    logic [PRG_W-1:0] prg_cnt;

    // Accept pulse edges unless a program cycle is running.
    always_comb begin
        acc_start = wr_start && (state != ST_PROG);
        acc_end   = wr_end && armed;
        new_cycle = acc_start && (state == ST_IDLE);
        wipe_we   = (state == ST_PROG) && (prg_cnt < PRG_W'(SECT));
        fill_we   = (state == ST_PROG) && (prg_cnt >= PRG_W'(SECT))
                    && (prg_cnt < PRG_W'(2 * SECT));
        idx       = prg_cnt[BYTE_BITS-1:0];
    end

    // State, window timer and program timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            armed   <= 1'b0;
            win_cnt <= '0;
            prg_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (acc_start) begin
                        state   <= ST_LOAD;
                        armed   <= 1'b1;
                        win_cnt <= '0;
                    end
                end
                ST_LOAD: begin
                    if (acc_start) begin
                        armed   <= 1'b1;
                        win_cnt <= '0;
                    end else if (acc_end) begin
                        armed   <= 1'b0;
                        win_cnt <= '0;
                    end else if (!armed) begin
                        if (win_cnt == WIN_W'(LOAD_WIN - 1)) begin
                            state   <= ST_PROG;
                            prg_cnt <= '0;
                        end else begin
                            win_cnt <= win_cnt + 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (prg_cnt == PRG_W'(PROG_CYC - 1)) begin
                        state <= ST_IDLE;
                    end else begin
                        prg_cnt <= prg_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: the program cycle ends only after its full length.
    a_r8_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_PROG) |-> ($past(prg_cnt) == PRG_W'(PROG_CYC - 1)));

    // R9: a pulse during programming never reopens a load window.
    a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && wr_start) |=> (state != ST_LOAD));

    // R5: the window lapses into programming, never straight back to idle.
    a_r5_win_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state != ST_IDLE));
endmodule

// File: rtl/spc_load_buf.sv
// Sector buffer: latches the sector on the first load of a cycle, stores
// bytes at their in-sector index, and keeps a per-byte loaded mask and the
// last loaded byte for polling. It presents buffer entries for the fill step.
module spc_load_buf
    import spc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        new_cycle,
    input  logic                        acc_start,
    input  logic                        acc_end,
    input  logic                        in_prog,
    input  logic [ADDR_W-1:0]           addr_s,
    input  logic [DATA_W-1:0]           data_end,
    input  logic [BYTE_BITS-1:0]        idx,
    output logic [ADDR_W-BYTE_BITS-1:0] sector,
    output logic [DATA_W-1:0]           last_data,
    output logic [DATA_W-1:0]           fill_data,
    output logic                        fill_loaded
);
    localparam int SECT = 1 << BYTE_BITS;

    logic [DATA_W-1:0]    buf_mem [SECT];
    logic [SECT-1:0]      mask;
    logic [BYTE_BITS-1:0] cur_idx;

    // Sector, current byte index, loaded mask and last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= '0;
            sector    <= '0;
            cur_idx   <= '0;
            last_data <= '0;
        end else begin
            if (new_cycle) begin
                mask   <= '0;
                sector <= addr_s[ADDR_W-1:BYTE_BITS];
            end
            if (acc_start) begin
                cur_idx <= addr_s[BYTE_BITS-1:0];
            end
            if (acc_end) begin
                mask[cur_idx] <= 1'b1;
                last_data     <= data_end;
            end
        end
    end

    // Buffer storage written at the end of each accepted pulse.
    always_ff @(posedge clk) begin
        if (acc_end) begin
            buf_mem[cur_idx] <= data_end;
        end
    end

    // Present the entry addressed by the fill step.
    always_comb begin
        fill_data   = buf_mem[idx];
        fill_loaded = mask[idx];
    end

    // R9: the buffer stays frozen while a program cycle runs.
    a_r9_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && $past(in_prog)) |-> ($stable(mask) && $stable(last_data)));
endmodule

// File: rtl/sector_prog_ctrl.sv
// Top of the sector program controller. It holds the 2^ADDR_W byte array,
// applies the erase and fill writes, and serves reads with one output
// register: true data when not programming, the polling word otherwise.
// Read data appears three clocks after the strobes settle.
module sector_prog_ctrl
    import spc_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int LOAD_WIN = 40,
    parameter int PROG_CYC = 300,
    parameter int UNDEF_X  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] UNDEF_VAL =
        (UNDEF_X != 0) ? {DATA_W{1'bx}} : {DATA_W{1'b1}};

    logic                        wr_start, wr_end, rd_act;
    logic [ADDR_W-1:0]           addr_s;
    logic [DATA_W-1:0]           data_end;
    spc_state_t                  state;
    logic                        acc_start, acc_end, new_cycle;
    logic                        wipe_we, fill_we;
    logic [BYTE_BITS-1:0]        idx;
    logic [ADDR_W-BYTE_BITS-1:0] sector;
    logic [DATA_W-1:0]           last_data, fill_data;
    logic                        fill_loaded;
    logic                        busy;
    logic [DATA_W-1:0]           arr [DEPTH];

    spc_strobe_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_start(wr_start), .wr_end(wr_end),
        .rd_act(rd_act), .addr_s(addr_s), .data_end(data_end)
    );

    spc_seq #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
        .state(state), .acc_start(acc_start), .acc_end(acc_end),
        .new_cycle(new_cycle), .wipe_we(wipe_we), .fill_we(fill_we), .idx(idx)
    );

    spc_load_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .new_cycle(new_cycle), .acc_start(acc_start),
        .acc_end(acc_end), .in_prog(busy), .addr_s(addr_s), .data_end(data_end),
        .idx(idx), .sector(sector), .last_data(last_data),
        .fill_data(fill_data), .fill_loaded(fill_loaded)
    );

    assign busy = (state == ST_PROG);

    // Array write port: erase step, then fill of loaded bytes.
    always_ff @(posedge clk) begin
        if (wipe_we) begin
            arr[{sector, idx}] <= UNDEF_VAL;
        end else if (fill_we && fill_loaded) begin
            arr[{sector, idx}] <= fill_data;
        end
    end

    // Registered read path with polling word during programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe <= rd_act;
            if (!rd_act) begin
                dq_out <= '0;
            end else if (busy) begin
                dq_out <= {~last_data[DATA_W-1], {(DATA_W-1){1'b0}}};
            end else begin
                dq_out <= arr[addr_s];
            end
        end
    end

    // R7: a read served during programming shows the inverted top bit.
    a_r7_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(busy)) |-> (dq_out[DATA_W-1] != last_data[DATA_W-1]));

    // R1: with no read condition the output is not driven.
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));
endmodule

// File: tb/tb_sector_prog_ctrl.sv
`timescale 1ns/1ps
module tb_sector_prog_ctrl;
    localparam int AW  = 9;
    localparam int WIN = 40;
    localparam int PRG = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dq_out;
    logic          dq_oe;
    int            total = 0;
    int            bad = 0;
    bit            finished = 1'b0;
    logic [7:0]    rv;

    always #2 clk = ~clk;

    sector_prog_ctrl #(.ADDR_W(AW), .DATA_W(8), .LOAD_WIN(WIN),
                       .PROG_CYC(PRG), .UNDEF_X(0)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [AW-1:0] mk(int s, int b);
        return AW'(s * 128 + b);
    endfunction

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_byte(logic [AW-1:0] a, logic [7:0] d);
        addr = a; din = d; oe_n = 1'b1; we_n = 1'b1; ce_n = 1'b0;
        wt(2);
        we_n = 1'b0;
        wt(4);
        we_n = 1'b1;
        wt(3);
        ce_n = 1'b1;
    endtask

    task automatic read_byte(logic [AW-1:0] a, output logic [7:0] d);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        wt(6);
        d = dq_out;
        oe_n = 1'b1; ce_n = 1'b1;
        wt(2);
    endtask

    task automatic wait_done(string tag, logic [AW-1:0] a, logic [7:0] exp);
        logic [7:0] d;
        d = 8'h00;
        for (int i = 0; i < 120; i++) begin
            read_byte(a, d);
            if (d === exp) break;
        end
        chk(tag, d, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wt(5);
        // R1: reset state
        chk("R1 dq_oe", {7'b0, dq_oe}, 8'h00);
        chk("R1 dq_out", dq_out, 8'h00);
        rst_n = 1'b1;
        wt(3);
        chk("R1 idle oe", {7'b0, dq_oe}, 8'h00);

        // R2: full sector 0 in reverse order
        for (int i = 127; i >= 0; i--) load_byte(mk(0, i), pat(i));
        wt(WIN + 5);
        read_byte(mk(0, 5), rv);
        chk("R7 poll word", rv, {~pat(0)[7], 7'b0});   // R7
        wt(150);
        read_byte(mk(0, 5), rv);
        chk("R8 still busy", rv, {~pat(0)[7], 7'b0});  // R8
        wait_done("R8 completion", mk(0, 0), pat(0));
        for (int i = 0; i < 128; i++) begin
            read_byte(mk(0, i), rv);
            chk("R2 sweep", rv, pat(i));
        end

        // R6: partial reload of sector 0
        for (int k = 0; k < 10; k++) load_byte(mk(0, 5 * k + 1), ~pat(5 * k + 1));
        wait_done("R6 done", mk(0, 46), ~pat(46));
        for (int i = 0; i < 128; i++) begin
            read_byte(mk(0, i), rv);
            if ((i % 5) == 1 && i <= 46) chk("R6 loaded", rv, ~pat(i));
            else chk("R6 erased", rv, 8'hFF);
        end

        // R5: lapsed window splits two loads
        load_byte(mk(1, 0), 8'h3C);
        wait_done("R5 first", mk(1, 0), 8'h3C);
        load_byte(mk(1, 1), 8'hC3);
        wait_done("R5 second", mk(1, 1), 8'hC3);
        read_byte(mk(1, 0), rv);
        chk("R5 split erased", rv, 8'hFF);

        // R5: gap inside the window joins
        load_byte(mk(2, 7), 8'h11);
        wt(25);
        load_byte(mk(2, 9), 8'h99);
        wait_done("R5 join done", mk(2, 9), 8'h99);
        read_byte(mk(2, 7), rv);
        chk("R5 join kept", rv, 8'h11);

        // R4: sector fixed by first load
        load_byte(mk(3, 2), 8'h5A);
        load_byte(mk(2, 4), 8'hA5);
        wait_done("R4 redirected", mk(3, 4), 8'hA5);
        read_byte(mk(3, 2), rv);
        chk("R4 first byte", rv, 8'h5A);
        read_byte(mk(2, 4), rv);
        chk("R4 other sector", rv, 8'hFF);

        // R9: write during programming is ignored
        load_byte(mk(1, 10), 8'h77);
        wt(WIN + 10);
        load_byte(mk(2, 7), 8'h00);
        wait_done("R9 done", mk(1, 10), 8'h77);
        read_byte(mk(2, 7), rv);
        chk("R9 untouched", rv, 8'h11);
        wt(WIN + 20);
        read_byte(mk(2, 7), rv);
        chk("R9 no new cycle", rv, 8'h11);

        // R3: address at later fall (ce_n), data at earlier rise (ce_n)
        oe_n = 1'b1; ce_n = 1'b1; we_n = 1'b0; addr = mk(0, 0); din = 8'h00;
        wt(3);
        addr = mk(3, 20);
        wt(3);
        ce_n = 1'b0;
        wt(3);
        addr = mk(0, 0); din = 8'h4E;
        wt(3);
        ce_n = 1'b1;
        wt(2);
        din = 8'hB1;
        wt(2);
        we_n = 1'b1;
        wait_done("R3 capture", mk(3, 20), 8'h4E);
        read_byte(mk(0, 0), rv);
        chk("R3 early addr unused", rv, 8'hFF);

        // R10: pulse with oe_n low is not a load
        addr = mk(2, 9); din = 8'h00; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        wt(2);
        we_n = 1'b0;
        wt(4);
        we_n = 1'b1;
        wt(2);
        oe_n = 1'b1; ce_n = 1'b1;
        wt(2);
        read_byte(mk(2, 9), rv);
        chk("R10 no poll", rv, 8'h99);
        wt(WIN + PRG);
        read_byte(mk(2, 9), rv);
        chk("R10 unchanged", rv, 8'h99);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule